// File: doc/BRIEF.md
# SCSI Controller Register Front End

This block is the host-facing register layer of a SCSI protocol controller. A byte-wide port reaches sixteen addresses. Each write lands in a write-side shadow bank. Some addresses are also mirrored into the bank that reads return. A write to the data address either feeds a transfer-data FIFO or, while the phase engine is collecting a command, appends to a command-byte buffer. A write to the command address is decoded at once. The decoder updates the status, interrupt, sequence-step and flags registers, raises the interrupt request, and issues one-cycle request strobes to the phase engine, which sits outside this block.

Bit 7 of a command byte is the DMA flag and bits 6:0 are the opcode. A command with the DMA flag set copies the three transfer-count bytes from the write side into the readable bank. A host read of the data address pops the FIFO. A read of the interrupt address returns the code and clears it on the same clock edge that ends the read. The phase engine reports sequence step and flags through a one-cycle update input.

Address map: 0/1/2 count low/mid/high, 3 data, 4 command, 5 status (write: bus id), 6 interrupt (write: timeout), 7 sequence step (write: sync period), 8 flags (write: sync offset), 9 config 1, 10 clock conversion, 11 test, 12 config 2, 13 config 3, 14 spare, 15 undefined.

Top module: `scsi_reg_front`

## Requirements
- R1: After reset every readable register reads 0x00, and irq, dma_mode, fifo_level, cmd_count, fifo_ovr and eng_req are all zero.
- R2: A write to address 0, 1 or 2 clears status bit 4 (terminal count), and does not change the readable count bytes.
- R3: While cmd_collect is high, a write to address 3 appends the byte to the command buffer and increments cmd_count, which saturates at CMD_DEPTH. The FIFO is unchanged. Collected byte k is readable on cmd_byte when cmd_idx = k.
- R4: While cmd_collect is low, a write to address 3 is dropped when fifo_level equals FIFO_DEPTH-1. In that case fifo_ovr pulses for one cycle. Otherwise the byte is stored. Reads of address 3 return the stored bytes in write order and pop them.
- R5: A write to address 4 makes address 4 read back the written byte. With bit 7 set, dma_mode goes high and addresses 0 to 2 read back the last values written there. With bit 7 clear, dma_mode goes low and the readable count bytes keep their values.
- R6: Opcode 0x01 (flush) sets the interrupt register to 0x08 and zeroes sequence step and flags. fifo_level is unchanged.
- R7: Opcode 0x03 (bus reset) sets the interrupt register to 0x80. It raises irq only when config 1 bit 6 is clear.
- R8: Opcode 0x12 (message accepted) sets the interrupt register to 0x20, zeroes sequence step and flags, and raises irq.
- R9: Opcode 0x18 (pad) sets status to exactly 0x10, sets the interrupt register to 0x08, zeroes sequence step, and leaves flags unchanged.
- R10: Opcode 0x11 (initiator complete) sets the interrupt register to 0x08 and status bit 2. Opcode 0x44 (enable selection) clears the interrupt register and does not raise irq. Opcode 0x45 (disable selection) clears the interrupt register and raises irq.
- R11: Writes to 9, 12, 13 and 14 read back. Writes to 5 through 8 do not change what those addresses read. Addresses 10, 11 and 15 read 0x00. A write to 15 changes no readable register.
- R12: A read of address 6 returns the interrupt code. From the next cycle on, the interrupt register reads 0x00 and irq is low.
- R13: Opcodes 0x10, 0x41, 0x42 and 0x43 each pulse eng_req bit 0, 1, 2 and 3 respectively for one cycle. An unlisted opcode (for example 0x7F) changes only the command register. Opcode 0x02 clears status, interrupt, sequence step, flags, irq, dma_mode, the FIFO and the command buffer.
- R14: A one-cycle eng_rpt loads eng_seq into the sequence-step register and eng_flags into the flags register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational while rd_en is high |
| irq | output | 1 | Interrupt request |
| cmd_collect | input | 1 | Phase engine is collecting command bytes |
| cmd_idx | input | IDX_W | Command buffer read index |
| cmd_byte | output | 8 | Command buffer byte at cmd_idx |
| cmd_count | output | CNT_W | Number of collected command bytes |
| fifo_level | output | LVL_W | Transfer FIFO occupancy |
| fifo_ovr | output | 1 | One-cycle pulse on a dropped FIFO write |
| dma_mode | output | 1 | DMA flag of the last command |
| eng_rpt | input | 1 | Phase engine status update strobe |
| eng_seq | input | 8 | Sequence step value to load |
| eng_flags | input | 8 | Flags value to load |
| eng_req | output | 4 | Request strobes: transfer, select, select with attention, select with attention and stop |

## Verification
The hardest situation to reach is a drop at the FIFO's capacity boundary. The bench pushes exactly FIFO_DEPTH-1 bytes and then one more. It checks the overrun pulse and the unchanged level, and it drains the FIFO to prove the dropped byte never entered. Interrupt-raising commands are mixed with reads that clear the code. This exercises the ordering between irq set, the read-clear and the config 1 suppression bit. Command-buffer saturation is reached by holding cmd_collect high across more writes than the buffer holds.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

  localparam int NREG = 16;
  localparam int NREQ = 4;

  typedef enum logic [3:0] {
    A_CNT_LO   = 4'd0,
    A_CNT_MID  = 4'd1,
    A_CNT_HI   = 4'd2,
    A_DATA     = 4'd3,
    A_CMD      = 4'd4,
    A_STAT     = 4'd5,
    A_INTR     = 4'd6,
    A_SEQ      = 4'd7,
    A_FLAGS    = 4'd8,
    A_CFG1     = 4'd9,
    A_CLKCV    = 4'd10,
    A_TEST     = 4'd11,
    A_CFG2     = 4'd12,
    A_CFG3     = 4'd13,
    A_SPARE    = 4'd14,
    A_NONE     = 4'd15
  } reg_addr_e;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_SOFTRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_XFER    = 7'h10;
  localparam logic [6:0] OP_ICDONE  = 7'h11;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_PAD     = 7'h18;
  localparam logic [6:0] OP_SETATN  = 7'h1A;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SELA    = 7'h42;
  localparam logic [6:0] OP_SELAS   = 7'h43;
  localparam logic [6:0] OP_ENSEL   = 7'h44;
  localparam logic [6:0] OP_DISSEL  = 7'h45;

  localparam logic [7:0] IC_DONE   = 8'h08;
  localparam logic [7:0] IC_DISC   = 8'h20;
  localparam logic [7:0] IC_BUSRST = 8'h80;

  localparam int ST_TC_BIT    = 4;
  localparam int ST_MI_BIT    = 2;
  localparam int CFG1_NOREP   = 6;

  localparam int REQ_XFER  = 0;
  localparam int REQ_SEL   = 1;
  localparam int REQ_SELA  = 2;
  localparam int REQ_SELAS = 3;

  typedef struct packed {
    logic            ld_intr;
    logic [7:0]      intr_val;
    logic            clr_seq;
    logic            clr_flags;
    logic            stat_tc_only;
    logic            stat_mi;
    logic            irq_always;
    logic            irq_unless_cfg;
    logic            soft_rst;
    logic [NREQ-1:0] req;
  } cmd_fx_t;

  function automatic logic [6:0] op_field(input logic [7:0] b);
    return b[6:0];
  endfunction

  function automatic logic dma_flag(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic is_count_addr(input logic [3:0] a);
    return (a == A_CNT_LO) || (a == A_CNT_MID) || (a == A_CNT_HI);
  endfunction

  function automatic logic mirrors_to_read(input logic [3:0] a);
    return (a == A_CFG1) || (a == A_CFG2) || (a == A_CFG3) || (a == A_SPARE);
  endfunction

  function automatic logic is_defined(input logic [3:0] a);
    return a != A_NONE;
  endfunction

endpackage

// File: rtl/scsi_rf_cmd_dec.sv
module scsi_rf_cmd_dec
  import scsi_rf_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_fx_t    fx
);

  always_comb begin
    fx = '0;
    case (op_field(cmd_byte))
      OP_FLUSH: begin
        fx.ld_intr   = 1'b1;
        fx.intr_val  = IC_DONE;
        fx.clr_seq   = 1'b1;
        fx.clr_flags = 1'b1;
      end
      OP_SOFTRST: fx.soft_rst = 1'b1;
      OP_BUSRST: begin
        fx.ld_intr        = 1'b1;
        fx.intr_val       = IC_BUSRST;
        fx.irq_unless_cfg = 1'b1;
      end
      OP_XFER:  fx.req[REQ_XFER] = 1'b1;
      OP_ICDONE: begin
        fx.ld_intr  = 1'b1;
        fx.intr_val = IC_DONE;
        fx.stat_mi  = 1'b1;
      end
      OP_MSGOK: begin
        fx.ld_intr    = 1'b1;
        fx.intr_val   = IC_DISC;
        fx.clr_seq    = 1'b1;
        fx.clr_flags  = 1'b1;
        fx.irq_always = 1'b1;
      end
      OP_PAD: begin
        fx.stat_tc_only = 1'b1;
        fx.ld_intr      = 1'b1;
        fx.intr_val     = IC_DONE;
        fx.clr_seq      = 1'b1;
      end
      OP_SEL:   fx.req[REQ_SEL]   = 1'b1;
      OP_SELA:  fx.req[REQ_SELA]  = 1'b1;
      OP_SELAS: fx.req[REQ_SELAS] = 1'b1;
      OP_ENSEL: begin
        fx.ld_intr  = 1'b1;
        fx.intr_val = 8'h00;
      end
      OP_DISSEL: begin
        fx.ld_intr    = 1'b1;
        fx.intr_val   = 8'h00;
        fx.irq_always = 1'b1;
      end
      default: fx = '0;
    endcase
  end

endmodule

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
  parameter  int DEPTH = 16,
  parameter  int W     = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign drop    = push && (level == LW'(DEPTH - 1));
  assign do_push = push && !drop;
  assign do_pop  = pop && (level != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/scsi_rf_cmdbuf.sv
module scsi_rf_cmdbuf #(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] count
);

  logic [7:0] mem [DEPTH];
  logic       room;

  assign room    = count < CW'(DEPTH);
  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && room && !clr) mem[count[IW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (clr)           count <= '0;
    else if (push && room)  count <= count + 1'b1;
  end

endmodule

// File: rtl/scsi_reg_front.sv
module scsi_reg_front
  import scsi_rf_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  parameter  int CMD_DEPTH  = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int CNT_W      = $clog2(CMD_DEPTH + 1),
  localparam int IDX_W      = $clog2(CMD_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             irq,
  input  logic             cmd_collect,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic [7:0]       cmd_byte,
  output logic [CNT_W-1:0] cmd_count,
  output logic [LVL_W-1:0] fifo_level,
  output logic             fifo_ovr,
  output logic             dma_mode,
  input  logic             eng_rpt,
  input  logic [7:0]       eng_seq,
  input  logic [7:0]       eng_flags,
  output logic [NREQ-1:0]  eng_req
);

  logic [7:0]      wbank [NREG];
  logic [7:0]      rbank [NREG];
  logic            irq_q, dma_q, ovr_q;
  logic [NREQ-1:0] req_q;

  // named events for the checker
  logic            cmd_wr, tc_wr, data_wr, intr_rd, data_rd;
  logic            fifo_push, fifo_drop, cmd_push, soft_clr;
  logic [7:0]      fifo_dout, stat_q, intr_q, cfg1_q;
  cmd_fx_t         fx;

  assign cmd_wr    = wr_en && (addr == A_CMD);
  assign tc_wr     = wr_en && is_count_addr(addr);
  assign data_wr   = wr_en && (addr == A_DATA);
  assign intr_rd   = rd_en && (addr == A_INTR);
  assign data_rd   = rd_en && (addr == A_DATA);
  assign fifo_push = data_wr && !cmd_collect;
  assign cmd_push  = data_wr && cmd_collect;
  assign soft_clr  = cmd_wr && fx.soft_rst;
  assign stat_q    = rbank[A_STAT];
  assign intr_q    = rbank[A_INTR];
  assign cfg1_q    = rbank[A_CFG1];

  scsi_rf_cmd_dec u_dec (
    .cmd_byte (wdata),
    .fx       (fx)
  );

  scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .push  (fifo_push),
    .pop   (data_rd),
    .din   (wdata),
    .dout  (fifo_dout),
    .level (fifo_level),
    .drop  (fifo_drop)
  );

  scsi_rf_cmdbuf #(.DEPTH(CMD_DEPTH)) u_cbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .push    (cmd_push),
    .din     (wdata),
    .rd_idx  (cmd_idx),
    .rd_byte (cmd_byte),
    .count   (cmd_count)
  );

  // write-side shadow bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wbank[i] <= 8'h00;
    end else if (wr_en && is_defined(addr)) begin
      wbank[addr] <= wdata;
    end
  end

  // read-visible bank and command side effects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rbank[i] <= 8'h00;
      irq_q <= 1'b0;
      dma_q <= 1'b0;
      ovr_q <= 1'b0;
      req_q <= '0;
    end else begin
      req_q <= '0;
      ovr_q <= fifo_drop;
      if (eng_rpt) begin
        rbank[A_SEQ]   <= eng_seq;
        rbank[A_FLAGS] <= eng_flags;
      end
      if (intr_rd) begin
        rbank[A_INTR] <= 8'h00;
        irq_q         <= 1'b0;
      end
      if (tc_wr) rbank[A_STAT][ST_TC_BIT] <= 1'b0;
      if (wr_en && mirrors_to_read(addr)) rbank[addr] <= wdata;
      if (cmd_wr) begin
        rbank[A_CMD] <= wdata;
        dma_q        <= dma_flag(wdata);
        if (dma_flag(wdata)) begin
          rbank[A_CNT_LO]  <= wbank[A_CNT_LO];
          rbank[A_CNT_MID] <= wbank[A_CNT_MID];
          rbank[A_CNT_HI]  <= wbank[A_CNT_HI];
        end
        if (fx.ld_intr)      rbank[A_INTR] <= fx.intr_val;
        if (fx.clr_seq)      rbank[A_SEQ] <= 8'h00;
        if (fx.clr_flags)    rbank[A_FLAGS] <= 8'h00;
        if (fx.stat_tc_only) rbank[A_STAT] <= 8'(1 << ST_TC_BIT);
        if (fx.stat_mi)      rbank[A_STAT][ST_MI_BIT] <= 1'b1;
        if (fx.irq_always)   irq_q <= 1'b1;
        if (fx.irq_unless_cfg && !cfg1_q[CFG1_NOREP]) irq_q <= 1'b1;
        req_q <= fx.req;
        if (fx.soft_rst) begin
          rbank[A_STAT]  <= 8'h00;
          rbank[A_INTR]  <= 8'h00;
          rbank[A_SEQ]   <= 8'h00;
          rbank[A_FLAGS] <= 8'h00;
          irq_q          <= 1'b0;
          dma_q          <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == A_DATA) rdata = (fifo_level != '0) ? fifo_dout : 8'h00;
      else                rdata = rbank[addr];
    end
  end

  assign irq      = irq_q;
  assign dma_mode = dma_q;
  assign fifo_ovr = ovr_q;
  assign eng_req  = req_q;

endmodule

// File: rtl/scsi_rf_chk.sv
module scsi_rf_chk
  import scsi_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CMD_DEPTH  = 16,
  parameter int LVL_W      = 5,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [3:0]       addr,
  input logic [7:0]       wdata,
  input logic             cmd_collect,
  input logic             irq,
  input logic             dma_mode,
  input logic [LVL_W-1:0] fifo_level,
  input logic [CNT_W-1:0] cmd_count,
  input logic [NREQ-1:0]  eng_req,
  input logic             fifo_ovr,
  input logic             fifo_drop,
  input logic [7:0]       stat_q,
  input logic [7:0]       cfg1_q
);

  // R2
  count_wr_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= 4'd2) |=> !stat_q[ST_TC_BIT]);

  // R3
  cmd_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd3 && cmd_collect && cmd_count < CNT_W'(CMD_DEPTH))
      |=> (cmd_count == $past(cmd_count) + 1'b1));

  // R4
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> fifo_ovr);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(FIFO_DEPTH - 1));

  // R5
  dma_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd4 && wdata[7] && wdata[6:0] != OP_SOFTRST) |=> dma_mode);

  // R5
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd4 && !wdata[7]) |=> !dma_mode);

  // R7
  busrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd4 && wdata[6:0] == OP_BUSRST && cfg1_q[CFG1_NOREP] && !irq)
      |=> !irq);

  // R8
  msg_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd4 && wdata[6:0] == OP_MSGOK) |=> irq);

  // R12
  intr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd6 && !wr_en) |=> !irq);

  // R13
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_req));

endmodule

bind scsi_reg_front scsi_rf_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .CMD_DEPTH  (CMD_DEPTH),
  .LVL_W      (LVL_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .cmd_collect (cmd_collect),
  .irq         (irq),
  .dma_mode    (dma_mode),
  .fifo_level  (fifo_level),
  .cmd_count   (cmd_count),
  .eng_req     (eng_req),
  .fifo_ovr    (fifo_ovr),
  .fifo_drop   (fifo_drop),
  .stat_q      (stat_q),
  .cfg1_q      (cfg1_q)
);

// File: tb/test_scsi_reg_front.sv
module test_scsi_reg_front;

  localparam int CLK_PERIOD = 10;
  localparam int FDEPTH     = 16;
  localparam int CDEPTH     = 16;
  localparam int WDOG       = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       cmd_collect = 1'b0;
  logic [3:0] cmd_idx = '0;
  logic [7:0] cmd_byte;
  logic [4:0] cmd_count;
  logic [4:0] fifo_level;
  logic       fifo_ovr, dma_mode;
  logic       eng_rpt = 1'b0;
  logic [7:0] eng_seq = '0, eng_flags = '0;
  logic [3:0] eng_req;

  int checks = 0;
  int errors = 0;

  scsi_reg_front #(.FIFO_DEPTH(FDEPTH), .CMD_DEPTH(CDEPTH)) i_scsi_reg_front (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cmd_collect(cmd_collect),
    .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .cmd_count(cmd_count),
    .fifo_level(fifo_level), .fifo_ovr(fifo_ovr), .dma_mode(dma_mode),
    .eng_rpt(eng_rpt), .eng_seq(eng_seq), .eng_flags(eng_flags),
    .eng_req(eng_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {write, addr, data}; a read entry holds the expected value
  localparam int NV = 32;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'd9,  8'h00}, {1'b1, 4'd3,  8'hA1}, {1'b1, 4'd3,  8'hA2},
    {1'b1, 4'd4,  8'h01}, {1'b0, 4'd6,  8'h08}, {1'b0, 4'd6,  8'h00},
    {1'b0, 4'd3,  8'hA1}, {1'b0, 4'd3,  8'hA2}, {1'b1, 4'd4,  8'h18},
    {1'b0, 4'd5,  8'h10}, {1'b0, 4'd6,  8'h08}, {1'b1, 4'd0,  8'h11},
    {1'b0, 4'd5,  8'h00}, {1'b1, 4'd1,  8'h22}, {1'b1, 4'd2,  8'h33},
    {1'b0, 4'd0,  8'h00}, {1'b1, 4'd4,  8'h80}, {1'b0, 4'd0,  8'h11},
    {1'b0, 4'd1,  8'h22}, {1'b0, 4'd2,  8'h33}, {1'b0, 4'd4,  8'h80},
    {1'b1, 4'd4,  8'h11}, {1'b0, 4'd5,  8'h04}, {1'b0, 4'd6,  8'h08},
    {1'b1, 4'd12, 8'h5A}, {1'b0, 4'd12, 8'h5A}, {1'b1, 4'd5,  8'h77},
    {1'b0, 4'd5,  8'h04}, {1'b1, 4'd10, 8'h99}, {1'b0, 4'd10, 8'h00},
    {1'b1, 4'd15, 8'hEE}, {1'b0, 4'd15, 8'h00}
  };

  localparam logic [6:0] REQ_OPS [4] = '{7'h10, 7'h41, 7'h42, 7'h43};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic report(input logic [7:0] s, input logic [7:0] f);
    @(negedge clk);
    eng_rpt = 1'b1; eng_seq = s; eng_flags = f;
    @(negedge clk);
    eng_rpt = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 dma_mode", dma_mode, 0);
    check("R1 fifo_level", fifo_level, 0);
    check("R1 cmd_count", cmd_count, 0);
    check("R1 eng_req", eng_req, 0);
    check("R1 fifo_ovr", fifo_ovr, 0);
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 8'h00, "R1 readable reg");

    // table: R2 R5 R6 R9 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][12]) wr(VEC[v][11:8], VEC[v][7:0]);
      else rd_chk(VEC[v][11:8], VEC[v][7:0], $sformatf("R2/R5/R6/R9/R10/R11/R12 vector %0d", v));
    end

    // R5 dma flag tracking
    check("R5 dma off after plain cmd", dma_mode, 0);
    wr(4'd4, 8'h81);
    check("R5 dma on", dma_mode, 1);
    wr(4'd4, 8'h00);
    check("R5 dma off", dma_mode, 0);
    rd_chk(4'd0, 8'h11, "R5 count kept without dma");

    // R7 bus reset, reported
    wr(4'd4, 8'h03);
    check("R7 irq raised", irq, 1);
    rd_chk(4'd6, 8'h80, "R7 intr code");
    check("R12 irq cleared by read", irq, 0);
    rd_chk(4'd6, 8'h00, "R12 intr cleared");
    // R7 bus reset, suppressed
    wr(4'd9, 8'h40);
    wr(4'd4, 8'h03);
    check("R7 irq suppressed", irq, 0);
    rd_chk(4'd6, 8'h80, "R7 intr code suppressed");
    wr(4'd9, 8'h00);
    rd_chk(4'd9, 8'h00, "R11 cfg1 readback");

    // R14 engine report
    report(8'h05, 8'h0C);
    rd_chk(4'd7, 8'h05, "R14 seq");
    rd_chk(4'd8, 8'h0C, "R14 flags");

    // R9 pad keeps flags
    wr(4'd4, 8'h18);
    rd_chk(4'd8, 8'h0C, "R9 flags kept");
    rd_chk(4'd7, 8'h00, "R9 seq zero");

    // R8 message accepted
    wr(4'd4, 8'h12);
    check("R8 irq", irq, 1);
    rd_chk(4'd7, 8'h00, "R8 seq");
    rd_chk(4'd8, 8'h00, "R8 flags");
    rd_chk(4'd6, 8'h20, "R8 intr");

    // R10 disable / enable selection
    wr(4'd4, 8'h45);
    check("R10 dissel irq", irq, 1);
    rd_chk(4'd6, 8'h00, "R10 dissel intr");
    wr(4'd4, 8'h01);
    wr(4'd4, 8'h44);
    check("R10 ensel no irq", irq, 0);
    rd_chk(4'd6, 8'h00, "R10 ensel intr");

    // R13 unknown opcode
    wr(4'd4, 8'h01);
    report(8'h03, 8'h07);
    wr(4'd4, 8'h7F);
    check("R13 unknown no irq", irq, 0);
    check("R13 unknown no req", eng_req, 0);
    rd_chk(4'd4, 8'h7F, "R13 unknown cmd reg");
    rd_chk(4'd7, 8'h03, "R13 unknown seq");
    rd_chk(4'd8, 8'h07, "R13 unknown flags");
    rd_chk(4'd6, 8'h08, "R13 unknown intr");

    // R13 engine strobes
    for (int k = 0; k < 4; k++) begin
      wr(4'd4, {1'b0, REQ_OPS[k]});
      check("R13 strobe pulse", eng_req, 32'(1 << k));
      @(negedge clk);
      check("R13 strobe ends", eng_req, 0);
    end

    // R6 flush keeps fifo
    wr(4'd3, 8'h31);
    wr(4'd3, 8'h32);
    check("R6 level before flush", fifo_level, 2);
    wr(4'd4, 8'h01);
    check("R6 level after flush", fifo_level, 2);

    // R13 soft reset
    wr(4'd4, 8'h18);
    wr(4'd4, 8'h02);
    check("R13 softrst fifo", fifo_level, 0);
    check("R13 softrst irq", irq, 0);
    rd_chk(4'd5, 8'h00, "R13 softrst status");
    rd_chk(4'd6, 8'h00, "R13 softrst intr");

    // R4 overrun boundary
    for (int i = 0; i < FDEPTH - 1; i++) wr(4'd3, 8'(i * 7 + 3));
    check("R4 level full", fifo_level, FDEPTH - 1);
    check("R4 no ovr yet", fifo_ovr, 0);
    wr(4'd3, 8'hFF);
    check("R4 ovr pulse", fifo_ovr, 1);
    check("R4 level held", fifo_level, FDEPTH - 1);
    for (int i = 0; i < FDEPTH - 1; i++) rd_chk(4'd3, 8'(i * 7 + 3), "R4 fifo order");
    check("R4 drained", fifo_level, 0);

    // R3 command collection
    cmd_collect = 1'b1;
    wr(4'd3, 8'hC0);
    wr(4'd3, 8'hC1);
    wr(4'd3, 8'hC2);
    check("R3 count", cmd_count, 3);
    check("R3 fifo untouched", fifo_level, 0);
    cmd_idx = 4'd1;
    #1;
    check("R3 byte", cmd_byte, 8'hC1);
    for (int i = 0; i < 20; i++) wr(4'd3, 8'(i));
    check("R3 saturate", cmd_count, CDEPTH);
    cmd_collect = 1'b0;
    wr(4'd4, 8'h02);
    check("R13 softrst cmdbuf", cmd_count, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule